// File: doc/BRIEF.md
# BCD Timekeeping Core with Snapshot

This block keeps calendar time in packed BCD: seconds, minutes, hours, day of month, month and a two-digit year. A prescaler divides a periodic `tick_in` strobe by `TICKS_PER_SEC` to form the one-second step. The carry from each field advances the next field on the same step. The day of month wraps at the real month length, with leap years taken into account.

Software does not read the counting core directly. It reads a bank of user registers through a plain register port. While neither control bit is set, the bank follows the core with one cycle of lag. Setting the read bit freezes the bank, so a multi-byte read sees one consistent instant. Setting the write bit holds the core still and opens the bank to software writes. Clearing the write bit loads the whole bank into the core in one edge and restarts the sub-second prescaler from zero.

The register port has no stream traffic. It is a single-cycle access with no back-pressure: a write takes effect on the edge where `reg_wr_en` is sampled, and `reg_rd_data` is a combinational view of the addressed register.

Top module: `rtc_bcd_core`

## Requirements
- R1: While the write bit is 0, the seconds field advances once for every `TICKS_PER_SEC` clock edges on which `tick_in` is 1, and on no other edge.
- R2: Seconds and minutes count 00 to 59 in BCD. The low nibble runs 0 to 9 and carries into the high nibble. 59 wraps to 00 and advances the next field on the same step.
- R3: Hours count 00 to 23 in BCD. Crossing from 09 gives 10, and 23 wraps to 00 and advances the day.
- R4: The day wraps to 01 after the month's last day: 30 for months 04, 06, 09 and 11; 29 for month 02 when the year is a multiple of 4, including 00; 28 for other Februaries; 31 for the rest. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R5: Address 0 is the control register. Bit 0 is the write bit and bit 1 is the read bit, and a read returns {6'b0, read, write}.
- R6: While both control bits are 0, addresses 1 to 6 (seconds, minutes, hours, day, month, year) read the core value of the previous cycle.
- R7: Writing the read bit to 1 captures the core value present at that edge. The user registers then stay unchanged for as long as the read bit is 1 and the write bit is 0.
- R8: Writes to addresses 1 to 6 update the user registers only while the write bit is 1. At other times they are ignored.
- R9: While the write bit is 1, the core does not change, whatever `tick_in` does.
- R10: On the edge where a control write clears a set write bit, the core takes all six user register values and the prescaler restarts from zero. The next second then begins only after a full `TICKS_PER_SEC` ticks.
- R11: After reset, the core and the user registers read 00:00:00, day 01, month 01, year 00, and both control bits are 0.
- R12: Address 7 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_in | input | 1 | Sub-second timebase strobe, one clock wide per tick |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 to 6 time fields |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Combinational read data for `reg_addr` |
| core_bcd | output | 48 | Live core {year, month, day, hour, minute, second} in BCD |
| ctrl_w | output | 1 | Write bit state |
| ctrl_r | output | 1 | Read bit state |

## Verification
The bench loads times that sit one second before each rollover: end of a 30-day month, Februaries of leap and non-leap years (year 00 included), 23:59:59 on the last day of year 99, and the nibble carries 09 to 10. A design with a wrong month table or leap rule would land on the wrong date or fail to carry into the month. The bench leaves the prescaler part-way through a second before a load. This catches a design that skips the timebase restart, because it would step one second too early. The snapshot is exercised with ticks arriving while the read bit is set, and with writes sent while the write bit is clear. A bank that kept tracking the core, or that accepted such writes, would return a value other than the one frozen.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

  localparam int NUM_FIELDS = 6;

  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DATE  = 3;
  localparam int F_MONTH = 4;
  localparam int F_YEAR  = 5;

  localparam logic [2:0] ADDR_CTRL = 3'd0;

  // lowest legal value of a field (day and month start at 1)
  function automatic logic [7:0] field_min(input int idx);
    return (idx == F_DATE || idx == F_MONTH) ? 8'h01 : 8'h00;
  endfunction

  // one BCD step with wrap from maxv to minv
  function automatic logic [7:0] bcd_next(input logic [7:0] v,
                                          input logic [7:0] maxv,
                                          input logic [7:0] minv);
    if (v == maxv)
      return minv;
    else if (v[3:0] >= 4'd9)
      return {v[7:4] + 4'd1, 4'h0};
    else
      return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // two-digit BCD year divisible by four
  function automatic logic is_leap(input logic [7:0] year);
    logic [3:0] ones;
    ones = year[3:0];
    if (!year[4])
      return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
    else
      return (ones == 4'd2) || (ones == 4'd6);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] month,
                                                input logic [7:0] year);
    case (month)
      8'h02:                      return is_leap(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic advance,
  output logic sec_pulse
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  assign sec_pulse = advance && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clear)
      cnt_q <= '0;
    else if (advance)
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/rtc_bcd_field.sv
`timescale 1ns/1ps
module rtc_bcd_field
  import rtc_pkg::*;
#(
  parameter logic [7:0] MIN_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       inc,
  input  logic [7:0] max_val,
  output logic [7:0] val,
  output logic       carry
);
  logic [7:0] val_q;

  assign val   = val_q;
  assign carry = inc && (val_q == max_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      val_q <= MIN_VAL;
    else if (load)
      val_q <= load_val;
    else if (inc)
      val_q <= bcd_next(val_q, max_val, MIN_VAL);
  end
endmodule

// File: rtl/rtc_user_regs.sv
`timescale 1ns/1ps
module rtc_user_regs
  import rtc_pkg::*;
#(
  parameter int NF = NUM_FIELDS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          track,
  input  logic [8*NF-1:0] core_flat,
  input  logic [NF-1:0] wr_sel,
  input  logic [7:0]    wr_data,
  output logic [8*NF-1:0] usr_flat
);
  for (genvar i = 0; i < NF; i++) begin : g_ureg
    localparam logic [7:0] RST_VAL = field_min(i);
    logic [7:0] u_q;
    assign usr_flat[8*i +: 8] = u_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        u_q <= RST_VAL;
      else if (track)
        u_q <= core_flat[8*i +: 8];
      else if (wr_sel[i])
        u_q <= wr_data;
    end
  end
endmodule

// File: rtl/rtc_bcd_core.sv
`timescale 1ns/1ps
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_in,
  input  logic                    reg_wr_en,
  input  logic [2:0]              reg_addr,
  input  logic [7:0]              reg_wr_data,
  output logic [7:0]              reg_rd_data,
  output logic [8*NUM_FIELDS-1:0] core_bcd,
  output logic                    ctrl_w,
  output logic                    ctrl_r
);
  localparam int NF = NUM_FIELDS;
  localparam int DW = 8 * NF;

  logic          w_q, r_q;
  logic          ctrl_wr;
  logic          w_fall;
  logic          cnt_en;
  logic          track;
  logic [NF-1:0] carry;
  logic [NF-1:0] wr_sel;
  logic [7:0]    field_val [NF];
  logic [7:0]    field_max [NF];
  logic [DW-1:0] usr_flat;
  logic          year_carry_unused;

  assign ctrl_wr = reg_wr_en && (reg_addr == ADDR_CTRL);
  assign w_fall  = ctrl_wr && w_q && !reg_wr_data[0];
  assign track   = !w_q && !r_q;
  assign ctrl_w  = w_q;
  assign ctrl_r  = r_q;
  assign year_carry_unused = carry[NF-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q <= 1'b0;
      r_q <= 1'b0;
    end else if (ctrl_wr) begin
      w_q <= reg_wr_data[0];
      r_q <= reg_wr_data[1];
    end
  end

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_psc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (w_fall),
    .advance  (tick_in && !w_q),
    .sec_pulse(cnt_en)
  );

  always_comb begin
    field_max[F_SEC]   = 8'h59;
    field_max[F_MIN]   = 8'h59;
    field_max[F_HOUR]  = 8'h23;
    field_max[F_DATE]  = month_last_day(field_val[F_MONTH], field_val[F_YEAR]);
    field_max[F_MONTH] = 8'h12;
    field_max[F_YEAR]  = 8'h99;
  end

  for (genvar i = 0; i < NF; i++) begin : g_field
    logic inc_i;
    if (i == 0) begin : g_first
      assign inc_i = cnt_en;
    end else begin : g_chain
      assign inc_i = carry[i-1];
    end

    rtc_bcd_field #(.MIN_VAL(field_min(i))) u_fld (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (w_fall),
      .load_val(usr_flat[8*i +: 8]),
      .inc     (inc_i),
      .max_val (field_max[i]),
      .val     (field_val[i]),
      .carry   (carry[i])
    );

    assign core_bcd[8*i +: 8] = field_val[i];
    assign wr_sel[i] = reg_wr_en && w_q && (reg_addr == 3'(i + 1));
  end

  rtc_user_regs #(.NF(NF)) u_ureg (
    .clk      (clk),
    .rst_n    (rst_n),
    .track    (track),
    .core_flat(core_bcd),
    .wr_sel   (wr_sel),
    .wr_data  (reg_wr_data),
    .usr_flat (usr_flat)
  );

  always_comb begin
    reg_rd_data = '0;
    if (reg_addr == ADDR_CTRL)
      reg_rd_data = {6'b0, r_q, w_q};
    for (int i = 0; i < NF; i++)
      if (reg_addr == 3'(i + 1))
        reg_rd_data = usr_flat[8*i +: 8];
  end
endmodule

// File: rtl/rtc_bcd_core_chk.sv
`timescale 1ns/1ps
module rtc_bcd_core_chk #(
  parameter int DW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_in,
  input logic [DW-1:0] core_bcd,
  input logic [DW-1:0] usr_flat,
  input logic          w_q,
  input logic          r_q,
  input logic          w_fall,
  input logic          cnt_en
);
  // R1
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_in && !w_fall) |=> $stable(core_bcd));

  // R9
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_q && !w_fall) |=> $stable(core_bcd));

  // R10
  release_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_fall |=> (core_bcd == $past(usr_flat)));

  // R7
  snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_q && !w_q) |=> $stable(usr_flat));

  // R6
  track_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_q && !w_q) |=> (usr_flat == $past(core_bcd)));

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && core_bcd[7:0] == 8'h59) |=> (core_bcd[7:0] == 8'h00));
endmodule

bind rtc_bcd_core rtc_bcd_core_chk #(.DW(8 * rtc_pkg::NUM_FIELDS)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_in (tick_in),
  .core_bcd(core_bcd),
  .usr_flat(usr_flat),
  .w_q     (w_q),
  .r_q     (r_q),
  .w_fall  (w_fall),
  .cnt_en  (cnt_en)
);

// File: tb/rtc_bcd_core_tb_top.sv
`timescale 1ns/1ps
module rtc_bcd_core_tb_top;
  localparam int TPS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [7:0]  reg_wr_data = 8'h00;
  logic [7:0]  reg_rd_data;
  logic [47:0] core_bcd;
  logic        ctrl_w, ctrl_r;

  int nchecks = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_bcd_core #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .core_bcd(core_bcd), .ctrl_w(ctrl_w), .ctrl_r(ctrl_r)
  );

  // ---------------- behavioural reference ----------------
  int m_s, m_mi, m_h, m_d, m_mo, m_y, m_psc;
  bit m_w, m_r;
  logic [7:0] m_u [6];
  logic [47:0] cold;
  logic [7:0] uo [6];
  bit wo, ro;

  function automatic logic [7:0] tob(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int frb(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic logic [47:0] mcore();
    return {tob(m_y), tob(m_mo), tob(m_d), tob(m_h), tob(m_mi), tob(m_s)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s = 0; m_mi = 0; m_h = 0; m_d = 1; m_mo = 1; m_y = 0; m_psc = 0;
      m_w = 0; m_r = 0;
      for (int i = 0; i < 6; i++) m_u[i] = (i == 3 || i == 4) ? 8'h01 : 8'h00;
    end else begin
      cold = mcore();
      for (int i = 0; i < 6; i++) uo[i] = m_u[i];
      wo = m_w; ro = m_r;
      if (reg_wr_en && reg_addr == 3'd0 && wo && !reg_wr_data[0]) begin
        m_s = frb(uo[0]); m_mi = frb(uo[1]); m_h = frb(uo[2]);
        m_d = frb(uo[3]); m_mo = frb(uo[4]); m_y = frb(uo[5]);
        m_psc = 0;
      end else if (!wo && tick_in) begin
        m_psc++;
        if (m_psc == TPS) begin
          m_psc = 0;
          m_s++;
          if (m_s == 60) begin
            m_s = 0; m_mi++;
            if (m_mi == 60) begin
              m_mi = 0; m_h++;
              if (m_h == 24) begin
                m_h = 0; m_d++;
                if (m_d > dim(m_mo, m_y)) begin
                  m_d = 1; m_mo++;
                  if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
                end
              end
            end
          end
        end
      end
      if (!wo && !ro)
        for (int i = 0; i < 6; i++) m_u[i] = cold[8*i +: 8];
      else if (wo && reg_wr_en && reg_addr >= 3'd1 && reg_addr <= 3'd6)
        m_u[reg_addr - 3'd1] = reg_wr_data;
      if (reg_wr_en && reg_addr == 3'd0) begin
        m_w = reg_wr_data[0]; m_r = reg_wr_data[1];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [47:0] act,
                     input logic [47:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [2:0] a);
    if (a == 3'd0) return {6'b0, m_r, m_w};
    if (a == 3'd7) return 8'h00;
    return m_u[a - 3'd1];
  endfunction

  // per-clock comparison against the reference
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(core_bcd == mcore(), "R1 core vs model", core_bcd, mcore());
      chk(reg_rd_data == model_rd(reg_addr), "R6 read vs model",
          48'(reg_rd_data), 48'(model_rd(reg_addr)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rd_data;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_in = 1'b1;
    repeat (n) @(negedge clk);
    tick_in = 1'b0;
    #1;
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, h, mi, s);
    wr(3'd0, 8'h01);
    wr(3'd1, s); wr(3'd2, mi); wr(3'd3, h);
    wr(3'd4, d); wr(3'd5, mo); wr(3'd6, y);
    wr(3'd0, 8'h00);
    #1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      nchecks++; nfail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk(core_bcd == 48'h00_01_01_00_00_00, "R11 core after reset", core_bcd,
        48'h00_01_01_00_00_00);
    rd(3'd0, d); chk(d == 8'h00, "R11 R5 ctrl after reset", 48'(d), 48'h00);
    rd(3'd4, d); chk(d == 8'h01, "R11 day after reset", 48'(d), 48'h01);
    // R12
    rd(3'd7, d); chk(d == 8'h00, "R12 address 7", 48'(d), 48'h00);
    // R8 write ignored while write bit clear
    wr(3'd1, 8'h30);
    rd(3'd1, d); chk(d == 8'h00, "R8 write ignored", 48'(d), 48'h00);
    // R1 prescaler
    ticks(3 * TPS);
    chk(core_bcd[7:0] == 8'h03, "R1 three seconds", 48'(core_bcd[7:0]), 48'h03);
    ticks(TPS - 1);
    chk(core_bcd[7:0] == 8'h03, "R1 partial second", 48'(core_bcd[7:0]), 48'h03);
    ticks(1);
    chk(core_bcd[7:0] == 8'h04, "R1 full second", 48'(core_bcd[7:0]), 48'h04);
    rd(3'd1, d); chk(d == 8'h04, "R6 tracking read", 48'(d), 48'h04);
    // leave prescaler part-way, then R9 hold
    ticks(3);
    wr(3'd0, 8'h01);
    rd(3'd0, d); chk(d == 8'h01, "R5 write bit readback", 48'(d), 48'h01);
    ticks(2 * TPS);
    chk(core_bcd == 48'h00_01_01_00_00_04, "R9 held while writing", core_bcd,
        48'h00_01_01_00_00_04);
    // R8 accepted, R10 load and timebase restart, R4 year wrap
    wr(3'd1, 8'h59); wr(3'd2, 8'h59); wr(3'd3, 8'h23);
    wr(3'd4, 8'h31); wr(3'd5, 8'h12); wr(3'd6, 8'h99);
    rd(3'd1, d); chk(d == 8'h59, "R8 write accepted", 48'(d), 48'h59);
    wr(3'd0, 8'h00);
    #1;
    chk(core_bcd == 48'h99_12_31_23_59_59, "R10 core loaded", core_bcd,
        48'h99_12_31_23_59_59);
    ticks(TPS - 1);
    chk(core_bcd == 48'h99_12_31_23_59_59, "R10 timebase restarted", core_bcd,
        48'h99_12_31_23_59_59);
    ticks(1);
    chk(core_bcd == 48'h00_01_01_00_00_00, "R4 R3 R2 year rollover", core_bcd,
        48'h00_01_01_00_00_00);
    // R4 month lengths
    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); ticks(TPS);
    chk(core_bcd == 48'h24_02_29_00_00_00, "R4 leap february", core_bcd,
        48'h24_02_29_00_00_00);
    set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); ticks(TPS);
    chk(core_bcd == 48'h23_03_01_00_00_00, "R4 plain february", core_bcd,
        48'h23_03_01_00_00_00);
    set_time(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); ticks(TPS);
    chk(core_bcd == 48'h00_02_29_00_00_00, "R4 year 00 leap", core_bcd,
        48'h00_02_29_00_00_00);
    set_time(8'h25, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59); ticks(TPS);
    chk(core_bcd == 48'h25_05_01_00_00_00, "R4 thirty day month", core_bcd,
        48'h25_05_01_00_00_00);
    set_time(8'h25, 8'h01, 8'h30, 8'h23, 8'h59, 8'h59); ticks(TPS);
    chk(core_bcd == 48'h25_01_31_00_00_00, "R4 thirty one day month", core_bcd,
        48'h25_01_31_00_00_00);
    // R3 and R2 nibble carries
    set_time(8'h25, 8'h01, 8'h05, 8'h09, 8'h59, 8'h59); ticks(TPS);
    chk(core_bcd == 48'h25_01_05_10_00_00, "R3 hour nibble carry", core_bcd,
        48'h25_01_05_10_00_00);
    set_time(8'h25, 8'h01, 8'h05, 8'h12, 8'h09, 8'h59); ticks(TPS);
    chk(core_bcd == 48'h25_01_05_12_10_00, "R2 minute nibble carry", core_bcd,
        48'h25_01_05_12_10_00);
    // R7 snapshot
    set_time(8'h25, 8'h06, 8'h15, 8'h10, 8'h20, 8'h30);
    wr(3'd0, 8'h02);
    ticks(TPS);
    chk(core_bcd[7:0] == 8'h31, "R7 core keeps counting", 48'(core_bcd[7:0]), 48'h31);
    rd(3'd1, d); chk(d == 8'h30, "R7 snapshot frozen", 48'(d), 48'h30);
    rd(3'd3, d); chk(d == 8'h10, "R7 snapshot hour", 48'(d), 48'h10);
    wr(3'd1, 8'h45);
    rd(3'd1, d); chk(d == 8'h30, "R8 write ignored under snapshot", 48'(d), 48'h30);
    rd(3'd0, d); chk(d == 8'h02, "R5 read bit readback", 48'(d), 48'h02);
    wr(3'd0, 8'h00);
    rd(3'd1, d); chk(d == 8'h31, "R6 tracking resumes", 48'(d), 48'h31);
    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule